// File: doc/BRIEF.md
# Triple Gate-Drive Fault Controller

This block is the digital control core of a three-channel power-switch gate driver. Each channel carries a logic command from the controller to a gate-drive output. The block passes the command only when four conditions hold: the shared enable is high, the supply is in the normal power mode, no overcurrent fault is being held, and the command level has outlasted a short deglitch interval. The analog parts are outside the block: the current-sense comparator, the supply-level detector and the output stages. Their results arrive here as clean synchronous digital levels.

An overcurrent flag from the sense comparator starts a long inhibition window. For the whole window every drive output is held low and the active-low alarm is asserted. Right after a trigger the sense flag is blanked for a short time, so that comparator ringing cannot extend the window. The supply-mode code selects one of three behaviours:
- Normal operation.
- Under-voltage: drives and alarm are low, but the current amplifier stays on.
- Standby: drives and alarm are low, and the current amplifier is switched off.

All time intervals are whole numbers of clock cycles. They are derived from the clock-frequency parameter and the interval parameters, which are given in nanoseconds.

Top module: `gate_fault_ctrl`

## Requirements
- R1: While synchronous reset is asserted, and on the first edge after it, all drive outputs are low, `alarm_n` is low and `amp_en` is low. The power mode resets to standby, and the fault and blanking timers are cleared.
- R2: In normal mode with enable high and no fault held, each `drive_out` bit equals its filtered channel input, and `alarm_n` is high.
- R3: Enable low, as sampled on a clock edge, makes every drive output low from that edge on, and it does not change `alarm_n`.
- R4: A sense flag sampled high while blanking is idle forces all drive outputs low and `alarm_n` low from that same edge, whatever the enable and channel inputs are.
- R5: After a trigger edge, drives and alarm stay inhibited for exactly HOLD cycles, where HOLD = INHIBIT_NS·CLK_HZ/1e9 (minimum 1).
- R6: During the BLANK edges that follow a trigger (BLANK = BLANK_NS·CLK_HZ/1e9), the sense flag is ignored. A flag that is still high on the next edge after that restarts the full window.
- R7: A channel input level reaches the filter output only when it has been sampled on GLITCH consecutive edges (GLITCH = GLITCH_NS·CLK_HZ/1e9). It takes effect on the GLITCH-th edge. Shorter pulses have no effect on `drive_out`.
- R8: Mode code 2'b10 or 2'b11 is standby: drives low, `alarm_n` low, `amp_en` low.
- R9: Mode code 2'b01 is under-voltage: drives low and `alarm_n` low, with `amp_en` high.
- R10: Mode code 2'b00 is normal. A mode change takes effect on the next clock edge. The fault timer and the channel filters keep running through any mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_trip | input | 1 | Overcurrent flag (positive sense above negative) |
| pwr_mode | input | 2 | Supply mode: 00 normal, 01 under-voltage, 1x standby |
| enable | input | 1 | Shared drive enable |
| chan_in | input | NCH | Channel command inputs |
| drive_out | output | NCH | Gate-drive commands |
| alarm_n | output | 1 | Active-low alarm |
| amp_en | output | 1 | Current-amplifier enable (low = high impedance) |

## Verification
Each result has a fixed latency:
- Mode, enable and sense changes show up at the outputs one edge after they are sampled.
- A channel input reaches its drive output on the GLITCH-th consecutive edge on which it is sampled.
- The alarm returns high exactly HOLD cycles after the trigger edge.

The bench drives all inputs just after a falling edge and advances a behavioural model on each rising edge. On every falling edge it compares all outputs with that model. The inhibition and glitch cases are also counted edge by edge and checked against the exact cycle counts: HOLD, BLANK+1+HOLD for a sense flag that is held high, and GLITCH−1 against GLITCH for pulses.

// File: rtl/gdrv_pkg.sv
// Shared types and helpers for the gate-drive fault controller.
// Assumes interval parameters are given in nanoseconds and clock in Hz.
package gdrv_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_LOWV  = 2'b01,
        PM_SLEEP = 2'b10
    } pmode_t;

    // Convert a nanosecond interval to whole clock cycles, at least one.
    function automatic int ns_to_cycles(longint clk_hz, longint ns);
        longint c;
        c = (clk_hz * ns) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    // Map the raw two-bit supply code onto a power mode; 11 is standby.
    function automatic pmode_t decode_mode(logic [1:0] code);
        pmode_t m;
        case (code)
            2'b00:   m = PM_RUN;
            2'b01:   m = PM_LOWV;
            default: m = PM_SLEEP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gdrv_deglitch.sv
// Single-channel pulse filter: the clean output takes the raw level only
// after the raw level has differed from it on DEPTH consecutive edges.
// Assumes raw is already synchronous to clk.
module gdrv_deglitch #(
    parameter int DEPTH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive disagreeing samples; accept the level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean   <= 1'b0;
            run_cnt <= '0;
        end else if (raw == clean) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            clean   <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gdrv_fault_timer.sv
// Overcurrent inhibition timer with post-trigger sense blanking.
// A sampled trip with blanking idle loads both counters; the hold counter
// defines the inhibition window, the blank counter masks further trips.
module gdrv_fault_timer #(
    parameter int HOLD_CYC  = 100000,
    parameter int BLANK_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_trip,
    output logic fault_active,
    output logic blank_busy
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [HW-1:0] hold_cnt;
    logic [BW-1:0] blank_cnt;
    logic          trig;

    // A trip counts only while the blanking counter is idle.
    assign trig = sense_trip && (blank_cnt == '0);

    // Load on trigger, otherwise count both windows down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            blank_cnt <= '0;
        end else if (trig) begin
            hold_cnt  <= HW'(HOLD_CYC);
            blank_cnt <= BW'(BLANK_CYC);
        end else begin
            if (hold_cnt != '0)  hold_cnt  <= hold_cnt - 1'b1;
            if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
        end
    end

    assign fault_active = (hold_cnt != '0);
    assign blank_busy   = (blank_cnt != '0);
endmodule

// File: rtl/gdrv_out_mask.sv
// Combinational output gating from registered state: power mode, enable,
// fault hold and filtered channel levels. No state of its own.
module gdrv_out_mask
    import gdrv_pkg::*;
#(
    parameter int NCH = 3
) (
    input  pmode_t         mode_q,
    input  logic           en_q,
    input  logic           fault_active,
    input  logic [NCH-1:0] chan_clean,
    output logic [NCH-1:0] drive_out,
    output logic           alarm_n,
    output logic           amp_en
);
    logic run_mode;

    // Decide every output from the current mode and fault state.
    always_comb begin
        run_mode  = (mode_q == PM_RUN);
        alarm_n   = run_mode && !fault_active;
        amp_en    = (mode_q != PM_SLEEP);
        drive_out = (run_mode && en_q && !fault_active) ? chan_clean : '0;
    end
endmodule

// File: rtl/gate_fault_ctrl.sv
// Top of the triple gate-drive fault controller. Registers mode and enable,
// filters each channel, runs the fault timer and gates the outputs.
// Assumes all inputs are synchronous to clk.
module gate_fault_ctrl
    import gdrv_pkg::*;
#(
    parameter longint CLK_HZ     = 100_000_000,
    parameter longint INHIBIT_NS = 1_000_000,
    parameter longint BLANK_NS   = 300,
    parameter longint GLITCH_NS  = 100,
    parameter int     NCH        = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sense_trip,
    input  logic [1:0]     pwr_mode,
    input  logic           enable,
    input  logic [NCH-1:0] chan_in,
    output logic [NCH-1:0] drive_out,
    output logic           alarm_n,
    output logic           amp_en
);
    localparam int HOLD_CYC   = ns_to_cycles(CLK_HZ, INHIBIT_NS);
    localparam int BLANK_CYC  = ns_to_cycles(CLK_HZ, BLANK_NS);
    localparam int GLITCH_CYC = ns_to_cycles(CLK_HZ, GLITCH_NS);

    pmode_t         mode_q;
    logic           en_q;
    logic           fault_active;
    logic           blank_busy;
    logic [NCH-1:0] chan_clean;

    // Capture mode and enable; reset lands in standby with drives off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_SLEEP;
            en_q   <= 1'b0;
        end else begin
            mode_q <= decode_mode(pwr_mode);
            en_q   <= enable;
        end
    end

    // One pulse filter per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        gdrv_deglitch #(.DEPTH(GLITCH_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (chan_in[g]),
            .clean (chan_clean[g])
        );
    end

    gdrv_fault_timer #(.HOLD_CYC(HOLD_CYC), .BLANK_CYC(BLANK_CYC)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sense_trip   (sense_trip),
        .fault_active (fault_active),
        .blank_busy   (blank_busy)
    );

    gdrv_out_mask #(.NCH(NCH)) u_mask (
        .mode_q       (mode_q),
        .en_q         (en_q),
        .fault_active (fault_active),
        .chan_clean   (chan_clean),
        .drive_out    (drive_out),
        .alarm_n      (alarm_n),
        .amp_en       (amp_en)
    );
endmodule

// File: rtl/gate_fault_ctrl_chk.sv
// Property checker for gate_fault_ctrl, attached by bind below.
module gate_fault_ctrl_chk
    import gdrv_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sense_trip,
    input logic [1:0]     pwr_mode,
    input logic [NCH-1:0] chan_in,
    input logic [NCH-1:0] drive_out,
    input logic           alarm_n,
    input logic           amp_en,
    input pmode_t         mode_q,
    input logic           en_q,
    input logic           fault_active,
    input logic           blank_busy,
    input logic [NCH-1:0] chan_clean
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (drive_out == '0 && !alarm_n && !amp_en)); // R1
    AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> drive_out == '0); // R3
    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) fault_active |-> (drive_out == '0 && !alarm_n)); // R4
    AST_TRIP_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (sense_trip && !blank_busy) |=> (fault_active && blank_busy)); // R5
    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (chan_in == chan_clean) |=> $stable(chan_clean)); // R7
    AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == PM_SLEEP) |-> (!amp_en && !alarm_n && drive_out == '0)); // R8
    AST_LOWV_AMP_ON: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == PM_LOWV) |-> (amp_en && !alarm_n && drive_out == '0)); // R9
    AST_MODE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (pwr_mode == 2'b00) |=> (mode_q == PM_RUN)); // R10
endmodule

bind gate_fault_ctrl gate_fault_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sense_trip   (sense_trip),
    .pwr_mode     (pwr_mode),
    .chan_in      (chan_in),
    .drive_out    (drive_out),
    .alarm_n      (alarm_n),
    .amp_en       (amp_en),
    .mode_q       (mode_q),
    .en_q         (en_q),
    .fault_active (fault_active),
    .blank_busy   (blank_busy),
    .chan_clean   (chan_clean)
);

// File: tb/gate_fault_ctrl_tb.sv
module gate_fault_ctrl_tb;
    localparam int NCH = 3;
    localparam int HOLD = 200;   // 2000 ns at 100 MHz
    localparam int BLNK = 30;    // 300 ns
    localparam int GLT  = 10;    // 100 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense = 1'b0;
    logic en = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [NCH-1:0] cin = '0;
    logic [NCH-1:0] drv;
    logic alarm_n, amp_en;

    always #5 clk = ~clk;

    gate_fault_ctrl #(
        .CLK_HZ(100_000_000), .INHIBIT_NS(2000), .BLANK_NS(300),
        .GLITCH_NS(100), .NCH(NCH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sense_trip(sense), .pwr_mode(mode),
        .enable(en), .chan_in(cin), .drive_out(drv), .alarm_n(alarm_n),
        .amp_en(amp_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1 reset";
    bit cmp_on = 1'b0;
    logic [NCH-1:0] seen_hi = '0;

    // Behavioural reference state
    int m_cnt [NCH];
    logic [NCH-1:0] m_flt = '0;
    int m_inh = 0;
    int m_blk = 0;
    int m_mode = 2;
    bit m_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flt = '0; m_inh = 0; m_blk = 0; m_mode = 2; m_en = 1'b0;
            for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (cin[i] != m_flt[i]) begin
                    m_cnt[i] = m_cnt[i] + 1;
                    if (m_cnt[i] == GLT) begin
                        m_flt[i] = cin[i];
                        m_cnt[i] = 0;
                    end
                end else m_cnt[i] = 0;
            end
            if (sense && m_blk == 0) begin
                m_inh = HOLD; m_blk = BLNK;
            end else begin
                if (m_inh > 0) m_inh = m_inh - 1;
                if (m_blk > 0) m_blk = m_blk - 1;
            end
            m_mode = (mode == 2'b11) ? 2 : int'(mode);
            m_en = en;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [NCH-1:0] e_drv;
            logic e_al, e_amp;
            bit run;
            run = (m_mode == 0);
            e_al = run && m_inh == 0;
            e_amp = (m_mode != 2);
            e_drv = (run && m_en && m_inh == 0) ? m_flt : '0;
            seen_hi = seen_hi | drv;
            n_chk++;
            if (drv !== e_drv || alarm_n !== e_al || amp_en !== e_amp) begin
                n_fail++;
                $display("FAIL %s model: actual drv=%b al=%b amp=%b expected drv=%b al=%b amp=%b",
                         phase, drv, alarm_n, amp_en, e_drv, e_al, e_amp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Count negedges with alarm low after a trip raised now; optional held trip.
    task automatic trip_window(int hold_for, int extra_at, output int cnt);
        cnt = 0;
        sense = 1'b1;
        for (int n = 1; n < HOLD + BLNK + 100; n++) begin
            @(negedge clk);
            #1;
            if (n == hold_for) sense = 1'b0;
            if (n == extra_at) sense = 1'b1;
            if (n == extra_at + 5) sense = 1'b0;
            if (!alarm_n) cnt++;
            else break;
        end
        sense = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int cnt;
        @(posedge clk);
        cmp_on = 1'b1;
        tick(2);
        check(drv == '0 && !alarm_n && !amp_en, "R1", "reset outputs", {drv, alarm_n, amp_en}, 0);

        phase = "R10 leave standby";
        rst_n = 1'b1; mode = 2'b00; en = 1'b1;
        tick(1);
        check(alarm_n == 1'b1 && amp_en == 1'b1, "R10", "alarm one edge after normal", alarm_n, 1);

        phase = "R2 follow";
        cin = 3'b101;
        tick(GLT - 1);
        check(drv == 3'b000, "R2", "drive before filter delay", drv, 0);
        tick(1);
        check(drv == 3'b101, "R2", "drive after filter delay", drv, 5);
        cin = 3'b010;
        tick(GLT);
        check(drv == 3'b010, "R2", "second pattern", drv, 2);
        cin = 3'b000;
        tick(GLT + 2);

        phase = "R7 short pulse";
        seen_hi = '0;
        cin[1] = 1'b1; tick(GLT - 1); cin[1] = 1'b0; tick(GLT + 3);
        check(seen_hi[1] == 1'b0, "R7", "short pulse passed", seen_hi[1], 0);
        phase = "R7 boundary pulse";
        seen_hi = '0;
        cin[1] = 1'b1; tick(GLT); cin[1] = 1'b0;
        check(drv[1] == 1'b1, "R7", "boundary pulse reached output", drv[1], 1);
        tick(GLT + 3);
        check(drv[1] == 1'b0, "R7", "boundary pulse ended", drv[1], 0);

        phase = "R3 enable low";
        cin = 3'b111; tick(GLT);
        en = 1'b0; tick(1);
        check(drv == '0 && alarm_n, "R3", "enable low outputs", drv, 0);
        en = 1'b1; tick(1);
        check(drv == 3'b111, "R3", "enable restored", drv, 7);

        phase = "R4 R5 trip window";
        sense = 1'b1; tick(1);
        check(drv == '0 && !alarm_n, "R4", "trip forces drives low", drv, 0);
        sense = 1'b0;
        tick(HOLD + 5);
        phase = "R5 R6 window length";
        trip_window(1, 10, cnt);
        check(cnt == HOLD, "R6", "blanked retrip did not extend", cnt, HOLD);
        check(drv == 3'b111, "R5", "drives back after window", drv, 7);
        tick(BLNK + 2);
        phase = "R6 held trip";
        trip_window(BLNK + 3, -10, cnt);
        check(cnt == BLNK + 1 + HOLD, "R6", "held trip retriggers after blank", cnt, BLNK + 1 + HOLD);
        tick(BLNK + 2);

        phase = "R8 standby";
        mode = 2'b10; tick(1);
        check(drv == '0 && !alarm_n && !amp_en, "R8", "standby code 10", {drv, alarm_n, amp_en}, 0);
        mode = 2'b11; tick(2);
        check(drv == '0 && !alarm_n && !amp_en, "R8", "standby code 11", {drv, alarm_n, amp_en}, 0);

        phase = "R9 under-voltage";
        mode = 2'b01; tick(1);
        check(drv == '0 && !alarm_n && amp_en, "R9", "under-voltage", {drv, alarm_n, amp_en}, 1);

        phase = "R10 mode exit";
        mode = 2'b00; tick(1);
        check(drv == 3'b111 && alarm_n, "R10", "normal one edge after exit", drv, 7);

        phase = "R10 timer through mode change";
        cnt = 0;
        sense = 1'b1;
        for (int n = 1; n < HOLD + 50; n++) begin
            @(negedge clk);
            #1;
            if (n == 1) sense = 1'b0;
            if (n == 50) mode = 2'b10;
            if (n == 70) mode = 2'b00;
            if (!alarm_n) cnt++;
            else break;
        end
        check(cnt == HOLD, "R10", "timer kept counting in standby", cnt, HOLD);
        tick(3);
        finish_up();
    end
endmodule